// File: doc/BRIEF.md
# Cache Push and Invalidate Controller

This block carries out cache-maintenance commands for a pair of small direct-mapped caches: one for instructions and one for data. A command names which caches to act on, how wide the selection is (one line, one page, or every entry), a physical address, and whether the requester holds supervisor privilege. The controller walks the tag entries of each selected cache in index order. It writes any selected dirty data line back through a valid/ready memory port. It then invalidates the selected entries, or only cleans them, depending on a keep bit.

Each cache has 16 lines of 16 bytes, with 32-bit physical addresses. A line address splits into tag bits [31:8], index bits [7:4] and offset bits [3:0]. The caches' refill path loads lines through a fill port. The hit path reads tag, valid and dirty state through a lookup port. Both ports are part of the normal cache interface, so the bench can place state in the caches and observe it.

Top module: `cmaint_ctrl`

## Requirements
- R1: After reset, cmd_ready is 1, done, trap and wb_valid are 0, and every lookup in either cache misses.
- R2: A command accepted with cmd_super = 0 leaves both caches unchanged and starts no write-back. It raises trap for exactly one cycle, in the cycle after acceptance, and does not raise done.
- R3: The cmd_caches encoding is: bit 0 selects the data cache and bit 1 selects the instruction cache. So 00 means neither, 01 data only, 10 instruction only and 11 both. A privileged command with 00 changes nothing and raises done in the cycle after acceptance. With 11, the data cache is walked first.
- R4: With cmd_scope = 0 (line), an entry is selected only when it is valid and its line address bits [31:4] equal cmd_addr[31:4].
- R5: With cmd_scope = 1 (page), a valid entry is selected when its line address matches cmd_addr on bits [31:12] while cfg_page_8k = 0, or on bits [31:13] while cfg_page_8k = 1.
- R6: With cmd_scope = 2 or 3 (all), every valid entry in the selected caches is selected, whatever the address.
- R7: Each selected data line that is dirty is offered on the write-back port before its state changes. The offer carries the line base address on wb_addr and the line's 128 bits on wb_data, with word 0 in bits [31:0]. Lines are offered in ascending index order. wb_valid and the payload stay stable until wb_ready is seen.
- R8: A selected data line is invalidated when cfg_dc_keep = 0. When cfg_dc_keep = 1 it stays valid and its dirty bit is cleared.
- R9: A selected instruction line is always invalidated, whatever cfg_dc_keep is. It is never written back, and an instruction line never reports dirty, even when it is filled with fill_dirty = 1.
- R10: cmd_ready is 1 only while the controller is idle. A command is taken only when cmd_valid and cmd_ready are both 1. done is a one-cycle pulse in the cycle after the last entry is processed, and cmd_ready returns to 1 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_caches | input | 2 | Cache select: bit 0 data, bit 1 instruction |
| cmd_scope | input | 2 | 0 line, 1 page, 2 or 3 all |
| cmd_addr | input | 32 | Physical address for line and page scope |
| cmd_super | input | 1 | Requester holds supervisor privilege |
| cfg_dc_keep | input | 1 | 1: data lines stay valid after a push |
| cfg_page_8k | input | 1 | 1: 8 KB pages, 0: 4 KB pages |
| done | output | 1 | One-cycle pulse when a command completes |
| trap | output | 1 | One-cycle pulse when an unprivileged command is refused |
| wb_valid | output | 1 | Write-back line offered |
| wb_ready | input | 1 | Memory accepts the offered line |
| wb_addr | output | 32 | Base address of the offered line |
| wb_data | output | 128 | Offered line contents, word 0 in bits [31:0] |
| fill_en | input | 1 | Refill write, honoured only while idle |
| fill_icache | input | 1 | Refill target: 1 instruction, 0 data |
| fill_addr | input | 32 | Refill line address |
| fill_dirty | input | 1 | Refilled data line starts dirty |
| fill_data | input | 128 | Refill line contents |
| lk_icache | input | 1 | Lookup target: 1 instruction, 0 data |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup address is held valid |
| lk_dirty | output | 1 | Lookup hit on a dirty data line |

## Verification
The bench places lines that sit in the same 8 KB page but in different 4 KB pages. A design that ignored the page-size bit, or used the wrong mask bit, would push and drop the neighbour page's line. Line scope is issued with an address inside the line rather than at its base, so a design that compares offset bits would miss the line. The bench runs the same data lines with the keep bit set and cleared, and runs an instruction-only command with the keep bit set. A design that applied the keep rule to instruction lines, or invalidated data lines while keeping, leaves the wrong hit pattern on the lookup port. Write-back ready is throttled in an irregular pattern, so a design that advanced without a handshake, or changed its payload while stalled, produces missing or mismatched scoreboard items. An unprivileged request and an empty cache select are both issued over a populated cache, and either one must leave every entry as it was.

// File: rtl/cmaint_pkg.sv
// Shared types for the cache push/invalidate controller.
// Assumes: two-bit scope code where values above PAGE all mean "every entry".
package cmaint_pkg;

    typedef enum logic [1:0] {
        SC_LINE = 2'd0,
        SC_PAGE = 2'd1,
        SC_ALL  = 2'd2,
        SC_ALL2 = 2'd3
    } cm_scope_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PUSH,
        ST_FIN,
        ST_TRAP
    } cm_state_e;

endpackage

// File: rtl/cmaint_tagstore.sv
// Tag, valid and dirty arrays of one direct-mapped cache, with an optional
// line data array (present for the data cache only).
// Assumes: fill and update never target the same cycle (fill is gated to idle
// by the parent, updates only happen while a walk is running).
module cmaint_tagstore #(
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 24,
    parameter int LINE_BITS = 128,
    parameter bit HAS_DATA  = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fill_we,
    input  logic [IDX_W-1:0]                   fill_idx,
    input  logic [TAG_W-1:0]                   fill_tag,
    input  logic                               fill_dirty,
    input  logic [LINE_BITS-1:0]               fill_data,
    input  logic                               upd_we,
    input  logic [IDX_W-1:0]                   upd_idx,
    input  logic                               upd_inval,
    input  logic [IDX_W-1:0]                   rd_idx,
    output logic [2**IDX_W-1:0]                valid_o,
    output logic [2**IDX_W-1:0]                dirty_o,
    output logic [2**IDX_W-1:0][TAG_W-1:0]     tag_o,
    output logic [LINE_BITS-1:0]               rd_data_o
);

    localparam int LINES = 2**IDX_W;

    logic [LINES-1:0]            valid_q;
    logic [LINES-1:0]            dirty_q;
    logic [LINES-1:0][TAG_W-1:0] tag_q;

    // Purpose: state bits, loaded by refill and cleaned/dropped by the walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            tag_q   <= '0;
        end else begin
            if (fill_we) begin
                valid_q[fill_idx] <= 1'b1;
                tag_q[fill_idx]   <= fill_tag;
                dirty_q[fill_idx] <= HAS_DATA ? fill_dirty : 1'b0;
            end
            if (upd_we) begin
                if (upd_inval) begin
                    valid_q[upd_idx] <= 1'b0;
                end
                dirty_q[upd_idx] <= 1'b0;
            end
        end
    end

    assign valid_o = valid_q;
    assign dirty_o = dirty_q;
    assign tag_o   = tag_q;

    generate
        if (HAS_DATA) begin : g_data
            logic [LINE_BITS-1:0] mem_q [LINES];

            // Purpose: line contents, written only by refill.
            always_ff @(posedge clk) begin
                if (fill_we) begin
                    mem_q[fill_idx] <= fill_data;
                end
            end

            assign rd_data_o = mem_q[rd_idx];
        end else begin : g_nodata
            logic unused_inputs;
            assign unused_inputs = ^{fill_data, fill_dirty, rd_idx};
            assign rd_data_o     = '0;
        end
    endgenerate

endmodule

// File: rtl/cmaint_match.sv
// Per-entry selection network: decides, for every line of one cache, whether
// the latched command selects it (line, page or all scope).
// Assumes: line address of entry i is {tag[i], i, zero offset}.
module cmaint_match
    import cmaint_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int OFF_W   = 4,
    parameter int PAGE_LO = 12
) (
    input  logic [2**IDX_W-1:0][ADDR_W-IDX_W-OFF_W-1:0] tag_i,
    input  logic [2**IDX_W-1:0]                         valid_i,
    input  cm_scope_e                                   scope_i,
    input  logic [ADDR_W-1:0]                           addr_i,
    input  logic                                        page_big_i,
    output logic [2**IDX_W-1:0]                         sel_o
);

    localparam int LINES = 2**IDX_W;

    logic [ADDR_W-1:0] page_mask;

    // Purpose: keep the address bits that name a page of the chosen size.
    always_comb begin
        if (page_big_i) begin
            page_mask = {ADDR_W{1'b1}} << (PAGE_LO + 1);
        end else begin
            page_mask = {ADDR_W{1'b1}} << PAGE_LO;
        end
    end

    generate
        for (genvar gi = 0; gi < LINES; gi++) begin : g_ent
            logic [ADDR_W-1:0] line_addr;
            logic              line_hit;
            logic              page_hit;

            assign line_addr = {tag_i[gi], IDX_W'(gi), {OFF_W{1'b0}}};
            assign line_hit  = (line_addr[ADDR_W-1:OFF_W] == addr_i[ADDR_W-1:OFF_W]);
            assign page_hit  = (((line_addr ^ addr_i) & page_mask) == '0);

            // Purpose: combine scope choice with the entry's valid bit.
            always_comb begin
                unique case (scope_i)
                    SC_LINE: sel_o[gi] = valid_i[gi] & line_hit;
                    SC_PAGE: sel_o[gi] = valid_i[gi] & page_hit;
                    default: sel_o[gi] = valid_i[gi];
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/cmaint_seq.sv
// Walk sequencer: steps through every index of the selected caches (data
// first), stalls on the write-back handshake for dirty data lines, issues the
// per-entry update and finishes with a done or trap pulse.
// Assumes: select and dirty vectors reflect current state each cycle.
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 priv_i,
    input  logic [1:0]           caches_i,
    input  logic                 keep_i,
    input  logic [2**IDX_W-1:0]  sel_d_i,
    input  logic [2**IDX_W-1:0]  sel_i_i,
    input  logic [2**IDX_W-1:0]  dirty_d_i,
    input  logic                 wb_ready_i,
    output logic                 idle_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 upd_d_we_o,
    output logic                 upd_i_we_o,
    output logic                 upd_inval_o,
    output logic                 wb_valid_o,
    output logic                 done_o,
    output logic                 trap_o
);

    cm_state_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic             on_icache_q;
    logic             also_icache_q;

    logic cur_sel;
    logic need_push;
    logic last_idx;
    logic step;
    logic upd;

    // Purpose: decide what the current index needs this cycle.
    always_comb begin
        cur_sel   = on_icache_q ? sel_i_i[idx_q] : sel_d_i[idx_q];
        need_push = !on_icache_q && sel_d_i[idx_q] && dirty_d_i[idx_q];
        last_idx  = (idx_q == {IDX_W{1'b1}});
        step      = ((st_q == ST_SCAN) && !(cur_sel && need_push))
                 || ((st_q == ST_PUSH) && wb_ready_i);
        upd       = ((st_q == ST_SCAN) && cur_sel && !need_push)
                 || ((st_q == ST_PUSH) && wb_ready_i);
    end

    // Purpose: state, index and cache-order registers of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= ST_IDLE;
            idx_q         <= '0;
            on_icache_q   <= 1'b0;
            also_icache_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        idx_q         <= '0;
                        on_icache_q   <= ~caches_i[0];
                        also_icache_q <= &caches_i;
                        if (!priv_i) begin
                            st_q <= ST_TRAP;
                        end else if (caches_i == 2'b00) begin
                            st_q <= ST_FIN;
                        end else begin
                            st_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN, ST_PUSH: begin
                    if ((st_q == ST_SCAN) && need_push) begin
                        st_q <= ST_PUSH;
                    end else if (step) begin
                        if (last_idx) begin
                            if (also_icache_q) begin
                                on_icache_q   <= 1'b1;
                                also_icache_q <= 1'b0;
                                idx_q         <= '0;
                                st_q          <= ST_SCAN;
                            end else begin
                                st_q <= ST_FIN;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_SCAN;
                        end
                    end
                end
                ST_FIN, ST_TRAP: st_q <= ST_IDLE;
                default:         st_q <= ST_IDLE;
            endcase
        end
    end

    assign idle_o      = (st_q == ST_IDLE);
    assign idx_o       = idx_q;
    assign upd_d_we_o  = upd && !on_icache_q;
    assign upd_i_we_o  = upd && on_icache_q;
    assign upd_inval_o = on_icache_q || !keep_i;
    assign wb_valid_o  = (st_q == ST_PUSH);
    assign done_o      = (st_q == ST_FIN);
    assign trap_o      = (st_q == ST_TRAP);

endmodule

// File: rtl/cmaint_ctrl.sv
// Cache push/invalidate controller top: holds both tag stores, latches the
// accepted command, runs the selection network per cache and the walker,
// and drives the write-back port, refill port and lookup port.
// Assumes: refill only while idle (ignored otherwise); configuration bits
// are sampled when the command is taken.
module cmaint_ctrl
    import cmaint_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 4,
    parameter int PAGE_LO = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_caches,
    input  logic [1:0]               cmd_scope,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic                     cmd_super,
    input  logic                     cfg_dc_keep,
    input  logic                     cfg_page_8k,
    output logic                     done,
    output logic                     trap,
    output logic                     wb_valid,
    input  logic                     wb_ready,
    output logic [ADDR_W-1:0]        wb_addr,
    output logic [WORD_W*WORDS-1:0]  wb_data,
    input  logic                     fill_en,
    input  logic                     fill_icache,
    input  logic [ADDR_W-1:0]        fill_addr,
    input  logic                     fill_dirty,
    input  logic [WORD_W*WORDS-1:0]  fill_data,
    input  logic                     lk_icache,
    input  logic [ADDR_W-1:0]        lk_addr,
    output logic                     lk_hit,
    output logic                     lk_dirty
);

    localparam int LINE_BITS = WORD_W * WORDS;
    localparam int OFF_W     = $clog2(LINE_BITS / 8);
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
    localparam int LINES     = 2**IDX_W;
    localparam int TAG_LO    = IDX_W + OFF_W;

    logic                        idle;
    logic                        accept;
    logic [ADDR_W-1:0]           lat_addr;
    cm_scope_e                   lat_scope;
    logic                        lat_page_big;
    logic                        lat_keep;

    logic [IDX_W-1:0]            walk_idx;
    logic                        upd_d_we;
    logic                        upd_i_we;
    logic                        upd_inval;

    logic [LINES-1:0]            d_valid, d_dirty, i_valid, i_dirty;
    logic [LINES-1:0][TAG_W-1:0] d_tag, i_tag;
    logic [LINES-1:0]            d_sel, i_sel;
    logic [LINE_BITS-1:0]        d_rd_data, i_rd_data;

    logic [IDX_W-1:0]            fill_idx;
    logic [TAG_W-1:0]            fill_tag;
    logic [IDX_W-1:0]            lk_idx;
    logic [TAG_W-1:0]            lk_tag;
    logic                        unused_bits;

    assign accept    = cmd_valid && idle;
    assign cmd_ready = idle;

    // Purpose: capture command address, scope and configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr     <= '0;
            lat_scope    <= SC_LINE;
            lat_page_big <= 1'b0;
            lat_keep     <= 1'b0;
        end else if (accept) begin
            lat_addr     <= cmd_addr;
            lat_scope    <= cm_scope_e'(cmd_scope);
            lat_page_big <= cfg_page_8k;
            lat_keep     <= cfg_dc_keep;
        end
    end

    assign fill_idx = fill_addr[TAG_LO-1:OFF_W];
    assign fill_tag = fill_addr[ADDR_W-1:TAG_LO];

    cmaint_tagstore #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS), .HAS_DATA(1'b1)
    ) u_dstore (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_en && idle && !fill_icache),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_dirty(fill_dirty),
        .fill_data (fill_data),
        .upd_we    (upd_d_we),
        .upd_idx   (walk_idx),
        .upd_inval (upd_inval),
        .rd_idx    (walk_idx),
        .valid_o   (d_valid),
        .dirty_o   (d_dirty),
        .tag_o     (d_tag),
        .rd_data_o (d_rd_data)
    );

    cmaint_tagstore #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS), .HAS_DATA(1'b0)
    ) u_istore (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_en && idle && fill_icache),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_dirty(fill_dirty),
        .fill_data (fill_data),
        .upd_we    (upd_i_we),
        .upd_idx   (walk_idx),
        .upd_inval (upd_inval),
        .rd_idx    (walk_idx),
        .valid_o   (i_valid),
        .dirty_o   (i_dirty),
        .tag_o     (i_tag),
        .rd_data_o (i_rd_data)
    );

    cmaint_match #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PAGE_LO(PAGE_LO)
    ) u_dmatch (
        .tag_i     (d_tag),
        .valid_i   (d_valid),
        .scope_i   (lat_scope),
        .addr_i    (lat_addr),
        .page_big_i(lat_page_big),
        .sel_o     (d_sel)
    );

    cmaint_match #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PAGE_LO(PAGE_LO)
    ) u_imatch (
        .tag_i     (i_tag),
        .valid_i   (i_valid),
        .scope_i   (lat_scope),
        .addr_i    (lat_addr),
        .page_big_i(lat_page_big),
        .sel_o     (i_sel)
    );

    cmaint_seq #(
        .IDX_W(IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .priv_i     (cmd_super),
        .caches_i   (cmd_caches),
        .keep_i     (lat_keep),
        .sel_d_i    (d_sel),
        .sel_i_i    (i_sel),
        .dirty_d_i  (d_dirty),
        .wb_ready_i (wb_ready),
        .idle_o     (idle),
        .idx_o      (walk_idx),
        .upd_d_we_o (upd_d_we),
        .upd_i_we_o (upd_i_we),
        .upd_inval_o(upd_inval),
        .wb_valid_o (wb_valid),
        .done_o     (done),
        .trap_o     (trap)
    );

    assign wb_addr = {d_tag[walk_idx], walk_idx, {OFF_W{1'b0}}};
    assign wb_data = d_rd_data;

    assign lk_idx = lk_addr[TAG_LO-1:OFF_W];
    assign lk_tag = lk_addr[ADDR_W-1:TAG_LO];

    // Purpose: hit and dirty report for the refill/hit path.
    always_comb begin
        if (lk_icache) begin
            lk_hit   = i_valid[lk_idx] && (i_tag[lk_idx] == lk_tag);
            lk_dirty = 1'b0;
        end else begin
            lk_hit   = d_valid[lk_idx] && (d_tag[lk_idx] == lk_tag);
            lk_dirty = lk_hit && d_dirty[lk_idx];
        end
    end

    assign unused_bits = ^{lk_addr[OFF_W-1:0], i_dirty, i_rd_data};

endmodule

// File: rtl/cmaint_chk.sv
// Protocol checker for cmaint_ctrl, attached by bind. Observes ports only.
module cmaint_chk #(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 128
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 cmd_super,
    input logic                 done,
    input logic                 trap,
    input logic                 wb_valid,
    input logic                 wb_ready,
    input logic [ADDR_W-1:0]    wb_addr,
    input logic [LINE_BITS-1:0] wb_data
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !done && !trap && !wb_valid));

    assert_trap_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_super) |=> (trap && !done && !wb_valid));

    assert_trap_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

    assert_no_done_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && trap));

    assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    assert_busy_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid || done || trap) |-> !cmd_ready);

endmodule

bind cmaint_ctrl cmaint_chk #(
    .ADDR_W   (ADDR_W),
    .LINE_BITS(WORD_W * WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_super(cmd_super),
    .done     (done),
    .trap     (trap),
    .wb_valid (wb_valid),
    .wb_ready (wb_ready),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data)
);

// File: tb/sim_cmaint_ctrl.sv
// Scoreboard bench: the command task models the caches, queues the expected
// write-backs, and a monitor pops and compares them at each handshake.
module sim_cmaint_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_caches = 2'b00;
    logic [1:0]   cmd_scope = 2'b00;
    logic [31:0]  cmd_addr = '0;
    logic         cmd_super = 1'b0;
    logic         cfg_dc_keep = 1'b0;
    logic         cfg_page_8k = 1'b0;
    logic         done, trap, wb_valid;
    logic         wb_ready = 1'b0;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;
    logic         fill_en = 1'b0;
    logic         fill_icache = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic         fill_dirty = 1'b0;
    logic [127:0] fill_data = '0;
    logic         lk_icache = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_hit, lk_dirty;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [31:0]  a;
        logic [127:0] d;
    } wb_item_t;
    wb_item_t exp_q[$];

    // model: index 0 data cache, 1 instruction cache
    logic         m_val [2][16];
    logic [23:0]  m_tag [2][16];
    logic         m_dty [2][16];
    logic [127:0] m_dat [16];

    always #5 clk = ~clk;

    cmaint_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_caches(cmd_caches), .cmd_scope(cmd_scope), .cmd_addr(cmd_addr),
        .cmd_super(cmd_super), .cfg_dc_keep(cfg_dc_keep), .cfg_page_8k(cfg_page_8k),
        .done(done), .trap(trap),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
        .fill_en(fill_en), .fill_icache(fill_icache), .fill_addr(fill_addr),
        .fill_dirty(fill_dirty), .fill_data(fill_data),
        .lk_icache(lk_icache), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_dirty(lk_dirty)
    );

    function automatic logic [127:0] pat(input logic [31:0] a);
        return {a ^ 32'h5A5A_0000, a + 32'd3, ~a, a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic bit picked(input int c, input int i, input logic [1:0] sc,
                                  input logic [31:0] a, input bit big);
        logic [31:0] la;
        la = {m_tag[c][i], 4'(i), 4'h0};
        if (!m_val[c][i]) return 1'b0;
        if (sc == 2'd0) return la[31:4] == a[31:4];
        if (sc == 2'd1) return big ? (la[31:13] == a[31:13]) : (la[31:12] == a[31:12]);
        return 1'b1;
    endfunction

    // write-back ready throttling, changed just after each rising edge
    initial begin
        logic [7:0] lfsr = 8'hA7;
        forever begin
            @(posedge clk);
            #1;
            lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wb_ready = lfsr[0] | lfsr[3];
        end
    end

    // monitor: pop and compare each write-back handshake (R7, R9)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wb_valid && wb_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 R9", "unexpected write-back",
                        {128'h0, wb_addr}, 160'h0);
                end else begin
                    wb_item_t e;
                    e = exp_q.pop_front();
                    chk(wb_addr == e.a, "R7", "write-back address",
                        {128'h0, wb_addr}, {128'h0, e.a});
                    chk(wb_data == e.d, "R7", "write-back data",
                        {32'h0, wb_data}, {32'h0, e.d});
                end
            end
        end
    end

    task automatic fill(input bit ic, input logic [31:0] a, input bit dty);
        @(negedge clk);
        fill_en     = 1'b1;
        fill_icache = ic;
        fill_addr   = a;
        fill_dirty  = dty;
        fill_data   = pat(a);
        @(negedge clk);
        fill_en = 1'b0;
        m_val[ic][a[7:4]] = 1'b1;
        m_tag[ic][a[7:4]] = a[31:8];
        m_dty[ic][a[7:4]] = ic ? 1'b0 : dty;
        if (!ic) m_dat[a[7:4]] = pat(a);
    endtask

    task automatic verify_all(input string rq);
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                lk_icache = c[0];
                lk_addr   = {m_tag[c][i], 4'(i), 4'h0};
                #2;
                chk((lk_hit == m_val[c][i]) &&
                    (lk_dirty == (m_val[c][i] && m_dty[c][i] && c == 0)),
                    rq, $sformatf("lookup cache %0d index %0d hit/dirty", c, i),
                    {158'h0, lk_hit, lk_dirty},
                    {158'h0, m_val[c][i], m_val[c][i] && m_dty[c][i] && c == 0});
            end
        end
    endtask

    task automatic issue(input string rq, input bit sup, input logic [1:0] caches,
                         input logic [1:0] sc, input logic [31:0] a,
                         input bit keep, input bit big);
        int n;
        // model update and expected write-backs (data cache first)
        if (sup) begin
            for (int c = 0; c < 2; c++) begin
                if (caches[c]) begin
                    for (int i = 0; i < 16; i++) begin
                        if (picked(c, i, sc, a, big)) begin
                            if (c == 0 && m_dty[0][i]) begin
                                wb_item_t e;
                                e.a = {m_tag[0][i], 4'(i), 4'h0};
                                e.d = m_dat[i];
                                exp_q.push_back(e);
                            end
                            if (c == 1 || !keep) m_val[c][i] = 1'b0;
                            m_dty[c][i] = 1'b0;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10", "ready before command", {159'h0, cmd_ready}, 160'h1);
        cmd_valid   = 1'b1;
        cmd_super   = sup;
        cmd_caches  = caches;
        cmd_scope   = sc;
        cmd_addr    = a;
        cfg_dc_keep = keep;
        cfg_page_8k = big;
        @(negedge clk);
        cmd_valid   = 1'b0;
        cfg_dc_keep = ~keep;
        cfg_page_8k = ~big;
        if (!sup) begin
            chk(trap && !done && !wb_valid, "R2", "trap in cycle after accept",
                {157'h0, trap, done, wb_valid}, {157'h0, 3'b100});
            @(negedge clk);
            chk(!trap && cmd_ready, "R2", "trap is one cycle",
                {158'h0, trap, cmd_ready}, {158'h0, 2'b01});
        end else if (caches == 2'b00) begin
            chk(done && !trap, "R3", "empty select completes at once",
                {158'h0, done, trap}, {158'h0, 2'b10});
            @(negedge clk);
            chk(!done && cmd_ready, "R10", "done pulse then ready",
                {158'h0, done, cmd_ready}, {158'h0, 2'b01});
        end else begin
            chk(!cmd_ready, "R10", "busy after accept", {159'h0, cmd_ready}, 160'h0);
            n = 0;
            while (!done && !trap && n < 5000) begin
                @(negedge clk);
                n++;
            end
            chk(done && !trap, "R10", "walk completes with done",
                {158'h0, done, trap}, {158'h0, 2'b10});
            @(negedge clk);
            chk(!done && cmd_ready, "R10", "done pulse then ready",
                {158'h0, done, cmd_ready}, {158'h0, 2'b01});
        end
        chk(exp_q.size() == 0, "R7", "all expected write-backs seen",
            160'(exp_q.size()), 160'h0);
        verify_all(rq);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 16; i++) begin
                m_val[c][i] = 1'b0;
                m_tag[c][i] = '0;
                m_dty[c][i] = 1'b0;
                if (c == 0) m_dat[i] = '0;
            end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready && !done && !trap && !wb_valid, "R1", "idle outputs after reset",
            {156'h0, cmd_ready, done, trap, wb_valid}, {156'h0, 4'b1000});
        verify_all("R1");

        // populate: data lines span two 4 KB pages of one 8 KB page
        fill(1'b0, 32'h1234_5010, 1'b1);
        fill(1'b0, 32'h1234_5020, 1'b0);
        fill(1'b0, 32'h1234_4040, 1'b1);
        fill(1'b0, 32'hABCD_E050, 1'b1);
        fill(1'b0, 32'h0000_0FF0, 1'b1);
        fill(1'b1, 32'h1234_5010, 1'b0);
        fill(1'b1, 32'h1234_5060, 1'b1);   // R9: dirty ignored for instruction lines
        fill(1'b1, 32'h5555_5070, 1'b0);
        verify_all("R9");

        // R2: unprivileged request over full caches does nothing
        issue("R2", 1'b0, 2'b11, 2'd2, 32'h0, 1'b0, 1'b0);
        // R3: privileged, neither cache selected
        issue("R3", 1'b1, 2'b00, 2'd2, 32'h0, 1'b0, 1'b0);
        // R4 R8: line scope, address inside line, invalidate
        issue("R4", 1'b1, 2'b01, 2'd0, 32'h1234_5018, 1'b0, 1'b0);
        // R5 R8: 4 KB page with keep: push and clean, other 4 KB page untouched
        fill(1'b0, 32'h1234_5010, 1'b1);
        issue("R5", 1'b1, 2'b01, 2'd1, 32'h1234_5000, 1'b1, 1'b0);
        // R5 R8: 8 KB page without keep: both 4 KB halves dropped
        issue("R8", 1'b1, 2'b01, 2'd1, 32'h1234_5000, 1'b0, 1'b1);
        // R9: instruction-only line scope with keep set still invalidates
        issue("R9", 1'b1, 2'b10, 2'd0, 32'h1234_5010, 1'b1, 1'b0);
        // R6 R3: both caches, all scope (encoding 3)
        fill(1'b0, 32'h1234_5020, 1'b1);
        issue("R6", 1'b1, 2'b11, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule